// File: doc/BRIEF.md
# Horizon Cost and Current-Limit Penalty Scorer

This block scores one candidate duty-cycle sequence for a predictive converter controller. An upstream predictor streams one record per PWM period of the prediction horizon. Each record holds the predicted average output voltage, the voltage reference, the candidate duty value for that period, and the inductor current predicted at the two switching instants of the period: the ON-to-OFF switch and the period end. A flag marks the last period of the horizon.

The block keeps two running totals. The tracking and effort total adds a weighted square of the voltage error and a weighted square of the duty step for every period but the last. The last period adds only a weighted square of the voltage error, using a separate terminal weight. The violation total adds the square of how far each current sample lies outside a lower and upper limit. It stays at exactly zero when every sample is inside the limits. All weights are powers of two and are applied as shifts. A start pulse opens a run, clears both totals and loads the duty value currently applied to the converter. That value is the reference for the first duty step. A one-cycle done pulse marks the final totals, and the totals then hold until the next start.

Top module: `pcacc_top`

## Requirements
- R1: While reset is high and on the first cycle after it, cost_total and viol_total are 0 and done is 0.
- R2: A start pulse clears both totals and done. They read 0 on the cycle after the start edge, and applied_duty is captured as the previous duty of the new run.
- R3: An accepted record that is not flagged last adds (du squared) shifted left by R_SH plus (dv squared) shifted left by Q_SH to cost_total. Here dv = v_avg - v_ref and du = duty - previous duty, both signed. The defaults are R_SH=0 and Q_SH=7, so the weights are 1 and 128.
- R4: An accepted record flagged last adds only (dv squared) shifted left by P_SH to cost_total, with P_SH=7 by default (weight 128). Its duty step has no effect on the total.
- R5: The duty step of the first record in a run is taken against applied_duty captured at start. Each later step is taken against the duty of the record just before it.
- R6: For each of i_mid and i_end, an accepted record adds (lim_low - i) squared to viol_total when i < lim_low, and (i - lim_high) squared when i > lim_high.
- R7: viol_total is exactly 0 after a run in which every current sample satisfies lim_low <= i <= lim_high, with both bounds inclusive.
- R8: If the edge that accepts the last-flagged record is edge E, done is high for exactly one cycle after edge E+1, when both totals are final. The totals then hold their values until the next start.
- R9: A record presented with smp_valid while no run is open changes neither total nor done. No run is open before the first start or after the last-flagged record. A record presented in the same cycle as start is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a run: clears totals and captures applied_duty |
| applied_duty | input | DATA_W | Duty currently applied to the converter, unsigned fraction |
| smp_valid | input | 1 | Record on the sample inputs is valid this cycle |
| smp_last | input | 1 | Record is the final period of the horizon |
| v_avg | input | DATA_W | Predicted average output voltage, unsigned fraction |
| v_ref | input | DATA_W | Voltage reference, unsigned fraction |
| duty | input | DATA_W | Candidate duty for this period, unsigned fraction |
| i_mid | input | DATA_W | Predicted inductor current at the ON-to-OFF switch |
| i_end | input | DATA_W | Predicted inductor current at period end |
| lim_low | input | DATA_W | Lower current limit |
| lim_high | input | DATA_W | Upper current limit |
| cost_total | output | ACC_W | Weighted tracking and effort total |
| viol_total | output | ACC_W | Squared current-limit excess total |
| done | output | 1 | One-cycle pulse: totals are final |

## Verification
The assertions assume that every run ends with a last-flagged record within HORIZON accepted records. They also assume that lim_low does not exceed lim_high and that both limits stay steady during a run. The stimulus keeps to these rules. Each run it builds has a length from 1 to HORIZON, always ends with the flag, and draws the lower limit from the bottom half of the range and the upper limit from the top half. Stray records sent outside any run are allowed by these assumptions, and the stimulus sends them on purpose to exercise the ignore rule.

// File: rtl/pcacc_pkg.sv
package pcacc_pkg;

  // Largest of three shift amounts, used to size the weighted terms.
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Bits needed to count up to n.
  function automatic int cnt_bits(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/pcacc_sqsh.sv
// Squares a signed difference and applies a power-of-two weight by shifting.
module pcacc_sqsh #(
  parameter int IN_W  = 13,
  parameter int SHIFT = 0,
  parameter int OUT_W = 2 * IN_W + SHIFT
) (
  input  logic signed [IN_W-1:0] d,
  output logic        [OUT_W-1:0] q
);
  localparam int SQ_W = 2 * IN_W;

  logic [IN_W-1:0] mag;
  logic [SQ_W-1:0] sq;

  always_comb begin
    mag = d[IN_W-1] ? IN_W'(-d) : IN_W'(d);
    sq  = SQ_W'(mag) * SQ_W'(mag);
    q   = OUT_W'(sq) << SHIFT;
  end

endmodule

// File: rtl/pcacc_front.sv
// Run control, duty history and the registered difference / excess stage.
module pcacc_front #(
  parameter int DATA_W  = 12,
  parameter int NCUR    = 2,
  parameter int HORIZON = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      in_valid,
  input  logic                      in_last,
  input  logic [DATA_W-1:0]         applied_duty,
  input  logic [DATA_W-1:0]         v_avg,
  input  logic [DATA_W-1:0]         v_ref,
  input  logic [DATA_W-1:0]         duty,
  input  logic [NCUR*DATA_W-1:0]    cur_flat,
  input  logic [DATA_W-1:0]         lim_low,
  input  logic [DATA_W-1:0]         lim_high,
  output logic                      s_valid,
  output logic                      s_last,
  output logic signed [DATA_W:0]    s_dv,
  output logic signed [DATA_W:0]    s_du,
  output logic [NCUR*DATA_W-1:0]    s_exc_lo,
  output logic [NCUR*DATA_W-1:0]    s_exc_hi
);
  localparam int CNT_W = pcacc_pkg::cnt_bits(HORIZON);

  logic              run_open;
  logic [DATA_W-1:0] prev_duty;
  logic [CNT_W-1:0]  n_taken;
  logic              take;

  assign take = in_valid && run_open && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_open  <= 1'b0;
      prev_duty <= '0;
      n_taken   <= '0;
      s_valid   <= 1'b0;
      s_last    <= 1'b0;
      s_dv      <= '0;
      s_du      <= '0;
    end else begin
      s_valid <= take;
      s_last  <= take && in_last;
      if (start) begin
        run_open  <= 1'b1;
        prev_duty <= applied_duty;
        n_taken   <= '0;
      end else if (take) begin
        prev_duty <= duty;
        n_taken   <= n_taken + 1'b1;
        if (in_last) run_open <= 1'b0;
      end
      if (take) begin
        s_dv <= $signed({1'b0, v_avg}) - $signed({1'b0, v_ref});
        s_du <= $signed({1'b0, duty})  - $signed({1'b0, prev_duty});
      end
    end
  end

  // One excess pair per current sample of the period.
  for (genvar c = 0; c < NCUR; c++) begin : g_cur
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] lo_n;
    logic [DATA_W-1:0] hi_n;

    always_comb begin
      cur  = cur_flat[c*DATA_W +: DATA_W];
      lo_n = (cur < lim_low)  ? (lim_low - cur)  : '0;
      hi_n = (cur > lim_high) ? (cur - lim_high) : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s_exc_lo[c*DATA_W +: DATA_W] <= '0;
        s_exc_hi[c*DATA_W +: DATA_W] <= '0;
      end else if (take) begin
        s_exc_lo[c*DATA_W +: DATA_W] <= lo_n;
        s_exc_hi[c*DATA_W +: DATA_W] <= hi_n;
      end
    end
  end

  // R9: no run ever absorbs more records than the horizon holds.
  a_r9_horizon_bound: assert property (@(posedge clk) disable iff (rst)
    take |-> (n_taken < CNT_W'(HORIZON)));

  // R9: the record that fills the horizon closes the run.
  a_r9_horizon_closes: assert property (@(posedge clk) disable iff (rst)
    (take && (n_taken == CNT_W'(HORIZON - 1))) |-> in_last);

  // R9: a record accepted with the last flag leaves the run closed.
  a_r9_closed_after_last: assert property (@(posedge clk) disable iff (rst)
    (take && in_last) |=> !run_open);

endmodule

// File: rtl/pcacc_top.sv
// Scores one duty-cycle candidate over the horizon: weighted cost and
// squared current-limit excess.
module pcacc_top #(
  parameter int DATA_W  = 12,
  parameter int HORIZON = 5,
  parameter int P_SH    = 7,
  parameter int Q_SH    = 7,
  parameter int R_SH    = 0,
  parameter int ACC_W   = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] applied_duty,
  input  logic              smp_valid,
  input  logic              smp_last,
  input  logic [DATA_W-1:0] v_avg,
  input  logic [DATA_W-1:0] v_ref,
  input  logic [DATA_W-1:0] duty,
  input  logic [DATA_W-1:0] i_mid,
  input  logic [DATA_W-1:0] i_end,
  input  logic [DATA_W-1:0] lim_low,
  input  logic [DATA_W-1:0] lim_high,
  output logic [ACC_W-1:0]  cost_total,
  output logic [ACC_W-1:0]  viol_total,
  output logic              done
);
  localparam int NCUR   = 2;
  localparam int DIFF_W = DATA_W + 1;
  localparam int SQ_W   = 2 * DIFF_W;
  localparam int MAX_SH = pcacc_pkg::max3(P_SH, Q_SH, R_SH);
  localparam int TERM_W = SQ_W + MAX_SH + 1;
  localparam int NEXC   = 2 * NCUR;
  localparam int VTERM_W = SQ_W + pcacc_pkg::cnt_bits(NEXC);

  logic                     s_valid;
  logic                     s_last;
  logic signed [DATA_W:0]   s_dv;
  logic signed [DATA_W:0]   s_du;
  logic [NCUR*DATA_W-1:0]   s_exc_lo;
  logic [NCUR*DATA_W-1:0]   s_exc_hi;
  logic [NCUR*DATA_W-1:0]   cur_flat;

  assign cur_flat = {i_end, i_mid};

  pcacc_front #(
    .DATA_W  (DATA_W),
    .NCUR    (NCUR),
    .HORIZON (HORIZON)
  ) front_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .in_valid     (smp_valid),
    .in_last      (smp_last),
    .applied_duty (applied_duty),
    .v_avg        (v_avg),
    .v_ref        (v_ref),
    .duty         (duty),
    .cur_flat     (cur_flat),
    .lim_low      (lim_low),
    .lim_high     (lim_high),
    .s_valid      (s_valid),
    .s_last       (s_last),
    .s_dv         (s_dv),
    .s_du         (s_du),
    .s_exc_lo     (s_exc_lo),
    .s_exc_hi     (s_exc_hi)
  );

  // Weighted squares of the tracking error and the duty step.
  logic [SQ_W+Q_SH-1:0] sq_dv_q;
  logic [SQ_W+P_SH-1:0] sq_dv_p;
  logic [SQ_W+R_SH-1:0] sq_du_r;

  pcacc_sqsh #(.IN_W(DIFF_W), .SHIFT(Q_SH), .OUT_W(SQ_W + Q_SH)) sq_dvq_i (
    .d (s_dv), .q (sq_dv_q));
  pcacc_sqsh #(.IN_W(DIFF_W), .SHIFT(P_SH), .OUT_W(SQ_W + P_SH)) sq_dvp_i (
    .d (s_dv), .q (sq_dv_p));
  pcacc_sqsh #(.IN_W(DIFF_W), .SHIFT(R_SH), .OUT_W(SQ_W + R_SH)) sq_du_i (
    .d (s_du), .q (sq_du_r));

  // Squared excess for every (sample, side) pair; even index = below, odd = above.
  logic [SQ_W-1:0] sq_exc [NEXC];

  for (genvar e = 0; e < NEXC; e++) begin : g_exc
    logic [DATA_W-1:0] exc;
    assign exc = (e % 2 == 0) ? s_exc_lo[(e/2)*DATA_W +: DATA_W]
                              : s_exc_hi[(e/2)*DATA_W +: DATA_W];
    pcacc_sqsh #(.IN_W(DIFF_W), .SHIFT(0), .OUT_W(SQ_W)) sq_exc_i (
      .d ($signed({1'b0, exc})), .q (sq_exc[e]));
  end

  logic [TERM_W-1:0]  cost_term;
  logic [VTERM_W-1:0] viol_term;

  always_comb begin
    if (s_last) cost_term = TERM_W'(sq_dv_p);
    else        cost_term = TERM_W'(sq_du_r) + TERM_W'(sq_dv_q);
    viol_term = '0;
    for (int e = 0; e < NEXC; e++) viol_term = viol_term + VTERM_W'(sq_exc[e]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cost_total <= '0;
      viol_total <= '0;
      done       <= 1'b0;
    end else if (start) begin
      cost_total <= '0;
      viol_total <= '0;
      done       <= 1'b0;
    end else begin
      done <= s_valid && s_last;
      if (s_valid) begin
        cost_total <= cost_total + ACC_W'(cost_term);
        viol_total <= viol_total + ACC_W'(viol_term);
      end
    end
  end

  // R1: reset leaves both totals empty and done low.
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cost_total == '0 && viol_total == '0 && !done));

  // R2: a start pulse empties the totals for the new run.
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (cost_total == '0 && viol_total == '0 && !done));

  // R3: the cost total only grows within a run.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cost_total >= $past(cost_total)));

  // R4: a terminal record with zero voltage error adds nothing, whatever its duty step.
  a_r4_terminal_no_step: assert property (@(posedge clk) disable iff (rst)
    (!start && s_valid && s_last && s_dv == '0) |=> $stable(cost_total));

  // R7: a record whose currents are inside the limits leaves the violation total alone.
  a_r7_inside_zero: assert property (@(posedge clk) disable iff (rst)
    (!start && s_valid && s_exc_lo == '0 && s_exc_hi == '0) |=> $stable(viol_total));

  // R8: done lasts one cycle.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: without a record in flight and without start, the totals hold.
  a_r8_totals_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && !s_valid) |=> ($stable(cost_total) && $stable(viol_total)));

endmodule

// File: tb/pcacc_top_tb_top.sv
module pcacc_top_tb_top;
  localparam int DW    = 12;
  localparam int HOR   = 5;
  localparam int ACCW  = 36;
  localparam longint WP = 128;
  localparam longint WQ = 128;
  localparam longint WR = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [DW-1:0]   applied_duty = '0;
  logic            smp_valid = 1'b0;
  logic            smp_last = 1'b0;
  logic [DW-1:0]   v_avg = '0, v_ref = '0, duty = '0;
  logic [DW-1:0]   i_mid = '0, i_end = '0;
  logic [DW-1:0]   lim_low = '0, lim_high = '0;
  logic [ACCW-1:0] cost_total, viol_total;
  logic            done;

  int n_chk  = 0;
  int n_fail = 0;

  int va [HOR];
  int vr [HOR];
  int dt [HOR];
  int im [HOR];
  int ie [HOR];

  always #5 clk = ~clk;

  pcacc_top #(.DATA_W(DW), .HORIZON(HOR), .ACC_W(ACCW)) dut_i (
    .clk (clk), .rst (rst), .start (start), .applied_duty (applied_duty),
    .smp_valid (smp_valid), .smp_last (smp_last), .v_avg (v_avg),
    .v_ref (v_ref), .duty (duty), .i_mid (i_mid), .i_end (i_end),
    .lim_low (lim_low), .lim_high (lim_high), .cost_total (cost_total),
    .viol_total (viol_total), .done (done));

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic longint excess_sq(input int i, input int lo, input int hi);
    longint e;
    e = 0;
    if (i < lo) e = longint'(lo - i) * longint'(lo - i);
    if (i > hi) e = longint'(i - hi) * longint'(i - hi);
    return e;
  endfunction

  function automatic longint step_cost(input int dv, input int du, input bit last);
    if (last) return WP * longint'(dv) * longint'(dv);
    return WR * longint'(du) * longint'(du) + WQ * longint'(dv) * longint'(dv);
  endfunction

  // Stray record while no run is open (R9).
  task automatic stray(input string tag);
    longint c0, v0;
    c0 = longint'(cost_total);
    v0 = longint'(viol_total);
    @(negedge clk);
    v_avg = 12'd4095; v_ref = 12'd0; duty = 12'd4095;
    i_mid = 12'd0; i_end = 12'd4095; lim_low = 12'd2000; lim_high = 12'd2100;
    smp_valid = 1'b1; smp_last = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; smp_last = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R9 cost unchanged"}, longint'(cost_total), c0);
    check({tag, " R9 viol unchanged"}, longint'(viol_total), v0);
    check({tag, " R9 done low"}, longint'(done), 0);
  endtask

  task automatic do_run(input int n, input int applied, input int lo, input int hi,
                        input string tag);
    longint ec, ev, cfin, vfin;
    int prev;
    ec = 0; ev = 0; prev = applied;
    @(negedge clk);
    start = 1'b1; applied_duty = DW'(applied);
    lim_low = DW'(lo); lim_high = DW'(hi);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 cost cleared"}, longint'(cost_total), 0);
    check({tag, " R2 viol cleared"}, longint'(viol_total), 0);
    for (int k = 0; k < n; k++) begin
      v_avg = DW'(va[k]); v_ref = DW'(vr[k]); duty = DW'(dt[k]);
      i_mid = DW'(im[k]); i_end = DW'(ie[k]);
      smp_valid = 1'b1; smp_last = (k == n - 1);
      // R3 / R4 / R5: weighted terms, first step against applied duty.
      ec += step_cost(va[k] - vr[k], dt[k] - prev, k == n - 1);
      // R6: both current samples of the period.
      ev += excess_sq(im[k], lo, hi) + excess_sq(ie[k], lo, hi);
      prev = dt[k];
      @(negedge clk);
    end
    smp_valid = 1'b0; smp_last = 1'b0;
    @(negedge clk);
    check({tag, " R8 done high"}, longint'(done), 1);
    check({tag, " R3 R4 R5 cost"}, longint'(cost_total), ec);
    check({tag, " R6 viol"}, longint'(viol_total), ev);
    cfin = longint'(cost_total);
    vfin = longint'(viol_total);
    @(negedge clk);
    check({tag, " R8 done single cycle"}, longint'(done), 0);
    check({tag, " R8 cost held"}, longint'(cost_total), cfin);
    check({tag, " R8 viol held"}, longint'(viol_total), vfin);
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20250227));
    repeat (3) @(negedge clk);
    check("R1 cost in reset", longint'(cost_total), 0);
    check("R1 done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cost after reset", longint'(cost_total), 0);
    check("R1 viol after reset", longint'(viol_total), 0);
    check("R1 done after reset", longint'(done), 0);

    stray("pre-start");

    // R7: everything on target and inside the limits, limits touched inclusively.
    for (int k = 0; k < HOR; k++) begin
      va[k] = 2000; vr[k] = 2000; dt[k] = 1500;
      im[k] = (k == 0) ? 800 : 1200; ie[k] = (k == 1) ? 3000 : 2500;
    end
    do_run(HOR, 1500, 800, 3000, "steady");
    check("R7 viol exactly zero", longint'(viol_total), 0);
    check("R7 cost zero on target", longint'(cost_total), 0);

    // R5: first step against applied duty, then record to record.
    for (int k = 0; k < HOR; k++) begin
      va[k] = 1000 + 10 * k; vr[k] = 1000; dt[k] = 1000 + 100 * k;
      im[k] = 1000; ie[k] = 1000;
    end
    do_run(HOR, 900, 500, 3500, "ramp");

    // Extreme errors and currents beyond both limits (R3, R6).
    for (int k = 0; k < HOR; k++) begin
      va[k] = (k % 2 == 0) ? 4095 : 0; vr[k] = (k % 2 == 0) ? 0 : 4095;
      dt[k] = (k % 2 == 0) ? 4095 : 0; im[k] = 0; ie[k] = 4095;
    end
    do_run(HOR, 0, 100, 4000, "extreme");

    // R4: one-record horizon carries only the terminal term.
    va[0] = 3000; vr[0] = 2900; dt[0] = 4000; im[0] = 50; ie[0] = 3900;
    do_run(1, 0, 100, 3800, "single");

    // R4: terminal duty jump with zero error adds nothing.
    va[0] = 1200; vr[0] = 1100; dt[0] = 1300; im[0] = 2000; ie[0] = 2000;
    va[1] = 1500; vr[1] = 1500; dt[1] = 4095; im[1] = 2000; ie[1] = 2000;
    do_run(2, 1250, 1000, 3000, "term-step");

    stray("post-done");

    for (int r = 0; r < 24; r++) begin
      int n;
      n = 1 + int'($urandom % HOR);
      for (int k = 0; k < HOR; k++) begin
        va[k] = int'($urandom % 4096); vr[k] = int'($urandom % 4096);
        dt[k] = int'($urandom % 4096);
        im[k] = int'($urandom % 4096); ie[k] = int'($urandom % 4096);
      end
      do_run(n, int'($urandom % 4096), int'($urandom % 2048),
             2048 + int'($urandom % 2048), $sformatf("rand%0d", r));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule